// File: doc/BRIEF.md
# Dual-Rail Ripple Adder with Completion Detection

This block adds two WIDTH-bit operands and a carry-in. Every bit travels on a pair of wires, a true rail and a false rail. A pair with one rail high carries a value. A pair with both rails low is NULL, which means no data yet. The pair with both rails high is illegal.

The adder is a ripple network. Each rail is an AND/OR function of input rails only, with no inverters anywhere. Because of this, an output pair stays NULL until the inputs it depends on have arrived, and during evaluation a rail can only rise.

A completion detector watches every sum pair and the carry-out pair. A small control stage turns that into `done` using hysteresis:

- `done` rises on the first clock edge at which every output pair holds data.
- `done` stays high while the outputs drain back to NULL.
- `done` falls on the first edge at which every output rail is low.

Users drive alternating waves: NULL, then data, then NULL again. They take the result once `done` is high and withdraw the inputs only after that.

A separate count reports how many of the carry pairs leaving each bit have resolved. This shows that operands without long propagate runs settle early.

Top module: `dualRailAdder`

## Requirements
- R1: When every input rail is low, every sum rail, both carry-out rails and `carryResolved` are zero. After reset, `done` is 0.
- R2: Bit i of a value is encoded as the rail pair (true, false), where (1,0) means 1, (0,1) means 0 and (0,0) means NULL. Sum bit i takes the rails of the dual-rail exclusive-OR of a[i], b[i] and the carry into bit i.
- R3: The carry out of each bit follows majority rails. The true rail is a1·b1 + a1·c1 + b1·c1. The false rail is a0·b0 + a0·c0 + b0·c0.
- R4: `done` rises only at a clock edge where every sum pair and the carry-out pair has at least one rail high. It is still 0 between the moment such data appears and that edge.
- R5: With all inputs valid, the value on `sumTrue` plus `coutTrue` at weight 2^WIDTH equals a + b + cin for every combination tested. `sumFalse` is the bitwise complement of `sumTrue`.
- R6: An output pair stays NULL until the rails it depends on are valid. With carry-in NULL, sum bit i is valid exactly when the carry into bit i has resolved, and `done` stays 0.
- R7: `carryResolved` counts the valid carry pairs leaving bits 0 to WIDTH-1. With carry-in NULL, a bit's carry resolves when a[i] equals b[i], or when the carry entering it has resolved.
- R8: During the return to NULL, `done` stays 1 while any output rail is high. It clears at the first clock edge after all output rails are low.
- R9: Raising input rails one pair at a time from NULL never lowers any output rail.
- R10: Inputs with no (1,1) pair never produce a (1,1) pair on any sum or carry-out output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the completion flag |
| rst_n | input | 1 | Active-low reset of the completion flag |
| opATrue | input | WIDTH | True rails of operand A |
| opAFalse | input | WIDTH | False rails of operand A |
| opBTrue | input | WIDTH | True rails of operand B |
| opBFalse | input | WIDTH | False rails of operand B |
| cinTrue | input | 1 | True rail of the carry-in |
| cinFalse | input | 1 | False rail of the carry-in |
| sumTrue | output | WIDTH | True rails of the sum |
| sumFalse | output | WIDTH | False rails of the sum |
| coutTrue | output | 1 | True rail of the carry-out |
| coutFalse | output | 1 | False rail of the carry-out |
| carryResolved | output | $clog2(WIDTH+1) | Number of per-bit carry pairs that hold data |
| done | output | 1 | Completion flag with hysteresis |

## Verification
A 4-bit instance is swept over all 512 operand and carry-in combinations. Each data wave is separated by a NULL wave, which separates arithmetic errors from rails that fail to return or a flag that fails to clear. A second sweep holds carry-in NULL over all operand pairs. It compares the resolved-carry count and the pattern of valid sum pairs against a propagate-run model, which separates locally generated or killed carries from chained ones. Single-pair ramps up from NULL expose any rail that falls during evaluation. Single-pair drains back to NULL show whether `done` clears early or late.

// File: rtl/drAddPkg.sv
package drAddPkg;

  // Summary flags the completion detector hands to the control stage.
  typedef struct packed {
    logic allValid;  // every output pair has one rail high
    logic allNull;   // every output rail is low
  } railStatus_t;

  // Sum rails of one bit: {true, false}. Only uncomplemented rails are used.
  function automatic logic [1:0] sumRails(input logic aT, input logic aF,
                                          input logic bT, input logic bF,
                                          input logic cT, input logic cF);
    logic xT, xF;
    xT = (aT & bF) | (aF & bT);
    xF = (aT & bT) | (aF & bF);
    return {(xT & cF) | (xF & cT), (xT & cT) | (xF & cF)};
  endfunction

  // Majority carry rails of one bit: {true, false}.
  function automatic logic [1:0] carryRails(input logic aT, input logic aF,
                                            input logic bT, input logic bF,
                                            input logic cT, input logic cF);
    return {(aT & bT) | (aT & cT) | (bT & cT),
            (aF & bF) | (aF & cF) | (bF & cF)};
  endfunction

endpackage

// File: rtl/drAddDatapath.sv
module drAddDatapath #(
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WIDTH-1:0]             opATrue,
  input  logic [WIDTH-1:0]             opAFalse,
  input  logic [WIDTH-1:0]             opBTrue,
  input  logic [WIDTH-1:0]             opBFalse,
  input  logic                         cinTrue,
  input  logic                         cinFalse,
  output logic [WIDTH-1:0]             sumTrue,
  output logic [WIDTH-1:0]             sumFalse,
  output logic                         coutTrue,
  output logic                         coutFalse,
  output logic [$clog2(WIDTH+1)-1:0]   carryResolved
);
  import drAddPkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);

  // Ripple network. The carry is a procedural chain so that no vector feeds itself.
  always_comb begin
    logic cT, cF;
    logic [1:0] s, k;
    logic [CNT_W-1:0] cnt;
    cT  = cinTrue;
    cF  = cinFalse;
    cnt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      s = sumRails(opATrue[i], opAFalse[i], opBTrue[i], opBFalse[i], cT, cF);
      k = carryRails(opATrue[i], opAFalse[i], opBTrue[i], opBFalse[i], cT, cF);
      sumTrue[i]  = s[1];
      sumFalse[i] = s[0];
      if (k[1] | k[0]) cnt = cnt + CNT_W'(1);
      cT = k[1];
      cF = k[0];
    end
    coutTrue      = cT;
    coutFalse     = cF;
    carryResolved = cnt;
  end

  logic inNull, inWellFormed, inComplete;
  assign inNull       = ~|{opATrue, opAFalse, opBTrue, opBFalse, cinTrue, cinFalse};
  assign inWellFormed = ~|(opATrue & opAFalse) && ~|(opBTrue & opBFalse) && !(cinTrue && cinFalse);
  assign inComplete   = &(opATrue | opAFalse) && &(opBTrue | opBFalse) && (cinTrue || cinFalse);

  // R1
  nullPropagate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inNull |-> (~|{sumTrue, sumFalse, coutTrue, coutFalse} && carryResolved == '0));

  // R10
  noIllegalPair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inWellFormed |-> (~|(sumTrue & sumFalse) && !(coutTrue && coutFalse)));

  // R7
  fullResolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inComplete |-> (&(sumTrue | sumFalse) && (coutTrue || coutFalse) &&
                    carryResolved == CNT_W'(WIDTH)));

endmodule

// File: rtl/drAddCompletion.sv
module drAddCompletion #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]       sumTrue,
  input  logic [WIDTH-1:0]       sumFalse,
  input  logic                   coutTrue,
  input  logic                   coutFalse,
  output drAddPkg::railStatus_t  status
);
  localparam int PAIRS = WIDTH + 1;

  logic [PAIRS-1:0] pairValid;

  // One OR per output pair; the carry-out takes the top slot.
  for (genvar g = 0; g < WIDTH; g++) begin : g_pair
    assign pairValid[g] = sumTrue[g] | sumFalse[g];
  end
  assign pairValid[PAIRS-1] = coutTrue | coutFalse;

  assign status.allValid = &pairValid;
  assign status.allNull  = ~|pairValid;

endmodule

// File: rtl/drAddControl.sv
module drAddControl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  drAddPkg::railStatus_t  status,
  output logic                   done
);
  // Hysteresis flag: set on full data, clear on full NULL, hold in between.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               done <= 1'b0;
    else if (status.allValid) done <= 1'b1;
    else if (status.allNull)  done <= 1'b0;
  end

  // R4
  doneRiseOnValid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(status.allValid));

  // R8
  doneFallOnNull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(status.allNull));

  // R8
  doneHoldsPartial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !status.allNull) |=> done);

endmodule

// File: rtl/dualRailAdder.sv
module dualRailAdder #(
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WIDTH-1:0]             opATrue,
  input  logic [WIDTH-1:0]             opAFalse,
  input  logic [WIDTH-1:0]             opBTrue,
  input  logic [WIDTH-1:0]             opBFalse,
  input  logic                         cinTrue,
  input  logic                         cinFalse,
  output logic [WIDTH-1:0]             sumTrue,
  output logic [WIDTH-1:0]             sumFalse,
  output logic                         coutTrue,
  output logic                         coutFalse,
  output logic [$clog2(WIDTH+1)-1:0]   carryResolved,
  output logic                         done
);
  drAddPkg::railStatus_t status;

  drAddDatapath #(.WIDTH(WIDTH)) datapath_i (
    .clk(clk), .rst_n(rst_n),
    .opATrue(opATrue), .opAFalse(opAFalse),
    .opBTrue(opBTrue), .opBFalse(opBFalse),
    .cinTrue(cinTrue), .cinFalse(cinFalse),
    .sumTrue(sumTrue), .sumFalse(sumFalse),
    .coutTrue(coutTrue), .coutFalse(coutFalse),
    .carryResolved(carryResolved)
  );

  drAddCompletion #(.WIDTH(WIDTH)) completion_i (
    .sumTrue(sumTrue), .sumFalse(sumFalse),
    .coutTrue(coutTrue), .coutFalse(coutFalse),
    .status(status)
  );

  drAddControl control_i (
    .clk(clk), .rst_n(rst_n), .status(status), .done(done)
  );

endmodule

// File: tb/dualRailAdder_tb_top.sv
module dualRailAdder_tb_top;
  localparam int BW  = 4;
  localparam int CW  = $clog2(BW + 1);
  localparam int NPR = 2 * BW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] aT = '0, aF = '0, bT = '0, bF = '0;
  logic cT = 1'b0, cF = 1'b0;
  logic [BW-1:0] sT, sF;
  logic oT, oF;
  logic [CW-1:0] resolved;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dualRailAdder #(.WIDTH(BW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .opATrue(aT), .opAFalse(aF), .opBTrue(bT), .opBFalse(bF),
    .cinTrue(cT), .cinFalse(cF),
    .sumTrue(sT), .sumFalse(sF), .coutTrue(oT), .coutFalse(oF),
    .carryResolved(resolved), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setNull();
    aT = '0; aF = '0; bT = '0; bF = '0; cT = 1'b0; cF = 1'b0;
  endtask

  task automatic setData(input logic [BW-1:0] a, input logic [BW-1:0] b, input logic c);
    aT = a; aF = ~a; bT = b; bF = ~b; cT = c; cF = ~c;
  endtask

  // Pair p: 0..BW-1 operand A, BW..2BW-1 operand B, 2BW carry-in.
  task automatic setPair(input int p, input logic [BW-1:0] a, input logic [BW-1:0] b,
                         input logic c, input bit on);
    if (p < BW) begin
      aT[p] = on & a[p]; aF[p] = on & ~a[p];
    end else if (p < 2 * BW) begin
      bT[p-BW] = on & b[p-BW]; bF[p-BW] = on & ~b[p-BW];
    end else begin
      cT = on & c; cF = on & ~c;
    end
  endtask

  function automatic int resolvedModel(input logic [BW-1:0] a, input logic [BW-1:0] b);
    int cnt = 0;
    bit prev = 0;
    for (int i = 0; i < BW; i++) begin
      prev = (a[i] == b[i]) ? 1'b1 : prev;
      cnt += prev;
    end
    return cnt;
  endfunction

  function automatic logic [BW-1:0] sumValidModel(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [BW-1:0] v;
    bit prev = 0;  // carry-in NULL
    for (int i = 0; i < BW; i++) begin
      v[i] = prev;
      prev = (a[i] == b[i]) ? 1'b1 : prev;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*BW+1:0] prevRails, curRails;
    bit expDone;
    setNull();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", done, 0);
    check({sT, sF, oT, oF} == '0, "R1 outputs null", {sT, sF, oT, oF}, 0);
    check(resolved == '0, "R1 resolved count", resolved, 0);

    // Exhaustive sweep with NULL waves in between
    for (int a = 0; a < (1 << BW); a++) begin
      for (int b = 0; b < (1 << BW); b++) begin
        for (int c = 0; c < 2; c++) begin
          int total;
          setNull();
          @(posedge clk); @(negedge clk);
          check(done == 1'b0, "R8 done cleared on null", done, 0);
          check({sT, sF, oT, oF} == '0, "R1 null in null out", {sT, sF, oT, oF}, 0);
          setData(BW'(a), BW'(b), 1'(c));
          #1;
          check(done == 1'b0, "R4 done waits for edge", done, 0);
          @(posedge clk); @(negedge clk);
          total = a + b + c;
          check(sT == BW'(total), "R2/R5 sum true rails", sT, total % (1 << BW));
          check(sF == ~BW'(total), "R5 sum false rails", sF, ~total & ((1 << BW) - 1));
          check({oT, oF} == {1'(total >> BW), ~1'(total >> BW)}, "R3 carry-out rails",
                {oT, oF}, {1'(total >> BW), ~1'(total >> BW)});
          check(~|(sT & sF) && !(oT && oF), "R10 no illegal pair", sT & sF, 0);
          check(done == 1'b1, "R4 done on full data", done, 1);
          check(resolved == CW'(BW), "R7 all carries resolved", resolved, BW);
        end
      end
    end

    // Carry-in held NULL: early resolution and partial validity
    for (int a = 0; a < (1 << BW); a++) begin
      for (int b = 0; b < (1 << BW); b++) begin
        setNull();
        @(posedge clk); @(negedge clk);
        aT = BW'(a); aF = ~BW'(a); bT = BW'(b); bF = ~BW'(b);
        @(posedge clk); @(negedge clk);
        check(int'(resolved) == resolvedModel(BW'(a), BW'(b)), "R7 resolved count",
              resolved, resolvedModel(BW'(a), BW'(b)));
        check((sT | sF) == sumValidModel(BW'(a), BW'(b)), "R6 sum pair validity",
              sT | sF, sumValidModel(BW'(a), BW'(b)));
        check(done == 1'b0, "R6 done low without carry-in", done, 0);
      end
    end

    // Monotonic ramp, one pair at a time
    for (int pat = 0; pat < 3; pat++) begin
      logic [BW-1:0] a, b;
      logic c;
      a = (pat == 0) ? 4'b1011 : (pat == 1) ? 4'b1111 : 4'b0101;
      b = (pat == 0) ? 4'b0110 : (pat == 1) ? 4'b0001 : 4'b1010;
      c = (pat != 2);
      setNull();
      @(posedge clk); @(negedge clk);
      prevRails = '0;
      for (int p = 0; p < NPR; p++) begin
        @(negedge clk);
        setPair(p, a, b, c, 1'b1);
        #1;
        curRails = {sT, sF, oT, oF};
        check((prevRails & ~curRails) == '0, "R9 no falling rail", prevRails & ~curRails, 0);
        prevRails = curRails;
      end
      @(posedge clk); @(negedge clk);
      check(done == 1'b1, "R4 done after ramp", done, 1);

      // Drain: carry-in first, then B, then A
      expDone = 1'b1;
      for (int q = 0; q < NPR; q++) begin
        int p;
        p = (q == 0) ? 2 * BW : (q <= BW) ? BW + q - 1 : q - BW - 1;
        @(negedge clk);
        check(done == expDone, "R8 done during drain", done, expDone);
        setPair(p, a, b, c, 1'b0);
        #1;
        expDone = |{sT, sF, oT, oF};
      end
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R8 done cleared after drain", done, 0);
      check({sT, sF, oT, oF} == '0, "R1 drained outputs null", {sT, sF, oT, oF}, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule